// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block decides when a DRAM memory controller must issue an auto-refresh. A free-running interval timer counts clock cycles against an effective refresh interval. That interval is derived from a programmed long interval, which is the cycle count for normal-temperature retention with the base row count. The effective interval is halved once when the high-temperature input or the newer-generation mode is set. It is halved once more for each doubling of the configured row count. When the timer expires, the block raises a refresh request and holds it until the command arbiter returns a grant pulse.

A granted refresh opens a busy window of a programmed number of cycles, which covers the refresh-cycle time of the device. The grant also advances a row-group counter. When that counter wraps after the configured number of row groups, the block emits a one-cycle pulse to mark one complete retention sweep.

A level handshake moves the device into and out of self-refresh. While self-refresh is acknowledged, the timer is frozen and no refresh is requested. On exit the block requests one refresh at once and restarts the timer from zero.

Top module: `rfs_sched`

## Requirements
- R1: A synchronous active-low reset clears the timer, the busy window and the row-group counter, and leaves `ref_req`, `busy`, `sweep_done` and `sr_ack` low.
- R2: The effective interval E is `ivl_long` shifted right by (S + H). S is 0, 1 or 2 for `row_sel` values 0, 1 and 2, and `row_sel` value 3 acts as 2. H is 1 when the interval is shortened and 0 otherwise. A result of zero is raised to 1. After the timer restarts, `ref_req` rises E cycles later. The first restart happens when reset is released.
- R3: Asserting `hot` or `gen_short`, or both, halves the interval once (H = 1).
- R4: `ref_req` stays high until a cycle in which `ref_gnt` is high, and is low from the following cycle. A `ref_gnt` that arrives while no request is pending changes neither `busy` nor `row_grp`.
- R5: The timer keeps running while a request is pending, so a new request rises E cycles after the previous one, whenever the grant came.
- R6: `busy` is high for exactly `trfc` cycles, starting the cycle after an accepted grant.
- R7: `row_grp` increments on each accepted grant. It wraps to 0 after reaching (ROW_BASE << S) - 1, and `sweep_done` is high for exactly the one cycle after the wrapping grant.
- R8: If the interval shortens while the timer already holds a count of at least E - 1 for the new E, `ref_req` rises on the next cycle.
- R9: When `sr_req` is high, no refresh window is open and no grant is being taken, `sr_ack` rises on the next cycle. In that same cycle any pending request is dropped. While `sr_ack` is high, `ref_req` stays low and grants have no effect on `row_grp` or `busy`.
- R10: When `sr_req` falls while `sr_ack` is high, `sr_ack` falls and `ref_req` rises on the next cycle. The timer restarts from zero in that cycle, so the following request comes E cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ivl_long | input | CNT_W | Long interval in cycles (normal temperature, base row count) |
| row_sel | input | 2 | Row-count select: 0 base, 1 double, 2 quadruple |
| hot | input | 1 | High-temperature indication, shortens interval |
| gen_short | input | 1 | Newer-generation mode, shortens interval |
| trfc | input | TRFC_W | Refresh-cycle busy window in cycles |
| ref_gnt | input | 1 | Grant pulse from the command arbiter |
| sr_req | input | 1 | Self-refresh request level |
| ref_req | output | 1 | Refresh request, held until granted |
| busy | output | 1 | Device within its refresh-cycle window |
| row_grp | output | ROW_W | Row-group counter |
| sweep_done | output | 1 | One-cycle pulse when a full sweep completes |
| sr_ack | output | 1 | Self-refresh active |

## Verification
Every result is one register away from its cause. `ref_req`, `busy`, `row_grp`, `sweep_done` and `sr_ack` all change at the first clock edge after the grant, expiry or self-refresh edge that causes them. The only exception is the request after a timer restart, which is due exactly E edges later. The bench counts edges since reset release and drives inputs and samples outputs on falling edges. It can therefore name the exact edge at which each result must first appear. It checks the cycle before that edge as well as the cycle after it, so an output that arrives one cycle early or late is caught.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        ROWS_1X = 2'd0,
        ROWS_2X = 2'd1,
        ROWS_4X = 2'd2,
        ROWS_RSV = 2'd3
    } row_size_e;

    // Number of halvings contributed by the row-count select; reserved acts as 4x.
    function automatic logic [1:0] size_shift(input logic [1:0] sel);
        return (sel == ROWS_RSV) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/rfs_interval_sel.sv
module rfs_interval_sel
    import rfs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] ivl_long,
    input  logic [1:0]       row_sel,
    input  logic             hot,
    input  logic             gen_short,
    output logic [CNT_W-1:0] eff_ivl
);
    logic [2:0]       halvings;
    logic [CNT_W-1:0] shifted;

    always_comb begin
        halvings = {1'b0, size_shift(row_sel)} + {2'b00, (hot | gen_short)};
        shifted  = ivl_long >> halvings;
        eff_ivl  = (shifted == '0) ? CNT_W'(1) : shifted;
    end

endmodule

// File: rtl/rfs_busy_timer.sv
module rfs_busy_timer #(
    parameter int TRFC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TRFC_W-1:0] trfc,
    output logic              busy
);
    logic [TRFC_W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load)
            left_d = trfc;
        else if (left_q != '0)
            left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign busy = (left_q != '0);

    // R6: an idle window stays idle unless a grant reloads it
    a_r6_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> !busy);

    // R6: a load of a non-zero window opens it on the next cycle
    a_r6_load_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (load && trfc != '0) |=> busy);

endmodule

// File: rtl/rfs_row_tracker.sv
module rfs_row_tracker
    import rfs_pkg::*;
#(
    parameter int ROW_BASE = 8192,
    parameter int ROW_W    = $clog2(ROW_BASE) + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [1:0]       row_sel,
    output logic [ROW_W-1:0] row_grp,
    output logic             sweep_done
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             sweep;
    } trk_t;

    trk_t             s_d, s_q;
    logic [ROW_W-1:0] last_grp;

    always_comb begin
        last_grp = (ROW_W'(ROW_BASE) << size_shift(row_sel)) - 1'b1;
        s_d      = s_q;
        s_d.sweep = 1'b0;
        if (step) begin
            if (s_q.row >= last_grp) begin
                s_d.row   = '0;
                s_d.sweep = 1'b1;
            end else begin
                s_d.row = s_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row_grp    = s_q.row;
    assign sweep_done = s_q.sweep;

    // R7: a completed sweep always leaves the counter at group zero
    a_r7_sweep_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (row_grp == '0));

    // R7: without a grant the counter holds its value
    a_r7_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row_grp) && !sweep_done);

endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
    import rfs_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TRFC_W   = 8,
    parameter int ROW_BASE = 8192,
    parameter int ROW_W    = $clog2(ROW_BASE) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  ivl_long,
    input  logic [1:0]        row_sel,
    input  logic              hot,
    input  logic              gen_short,
    input  logic [TRFC_W-1:0] trfc,
    input  logic              ref_gnt,
    input  logic              sr_req,
    output logic              ref_req,
    output logic              busy,
    output logic [ROW_W-1:0]  row_grp,
    output logic              sweep_done,
    output logic              sr_ack
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic             sr;
    } sch_t;

    sch_t             s_d, s_q;
    logic [CNT_W-1:0] eff_ivl;
    logic             expire;
    logic             take;
    logic             sr_enter;
    logic             sr_exit;

    rfs_interval_sel #(.CNT_W(CNT_W)) u_ivl (
        .ivl_long (ivl_long),
        .row_sel  (row_sel),
        .hot      (hot),
        .gen_short(gen_short),
        .eff_ivl  (eff_ivl)
    );

    rfs_busy_timer #(.TRFC_W(TRFC_W)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .load (take),
        .trfc (trfc),
        .busy (busy)
    );

    rfs_row_tracker #(.ROW_BASE(ROW_BASE), .ROW_W(ROW_W)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (take),
        .row_sel   (row_sel),
        .row_grp   (row_grp),
        .sweep_done(sweep_done)
    );

    always_comb begin
        take     = ref_gnt && s_q.req && !s_q.sr;
        expire   = !s_q.sr && (s_q.cnt >= (eff_ivl - 1'b1));
        sr_enter = sr_req && !s_q.sr && !busy && !take;
        sr_exit  = s_q.sr && !sr_req;

        s_d = s_q;
        if (s_q.sr) begin
            // timer frozen while the device refreshes itself
            if (sr_exit) begin
                s_d.sr  = 1'b0;
                s_d.req = 1'b1;
                s_d.cnt = '0;
            end
        end else begin
            s_d.cnt = expire ? '0 : s_q.cnt + 1'b1;
            if (expire)
                s_d.req = 1'b1;
            else if (take)
                s_d.req = 1'b0;
            if (sr_enter) begin
                s_d.sr  = 1'b1;
                s_d.req = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ref_req = s_q.req;
    assign sr_ack  = s_q.sr;

    // R9: no controller refresh is requested during self-refresh
    a_r9_quiet_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> !ref_req);

    // R4: a pending request survives every cycle without a grant or self-refresh
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt && !sr_req) |=> ref_req);

    // R10: leaving self-refresh always produces a request
    a_r10_exit_request: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_ack && !sr_req) |=> (ref_req && !sr_ack));

    // R9: entry is refused while a refresh window is open
    a_r9_no_entry_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_ack && busy) |=> !sr_ack);

endmodule

// File: tb/rfs_sched_test.sv
module rfs_sched_test;
    localparam int CNT_W    = 16;
    localparam int TRFC_W   = 8;
    localparam int ROW_BASE = 4;
    localparam int ROW_W    = $clog2(ROW_BASE) + 3;
    localparam int NV       = 10;

    localparam int V_IVL [NV] = '{100, 100, 100, 100, 100, 100, 100, 1, 15625, 15625};
    localparam int V_SEL [NV] = '{0,   0,   0,   1,   2,   2,   3,   0, 0,     0};
    localparam int V_HOT [NV] = '{0,   1,   0,   0,   0,   1,   0,   1, 0,     1};
    localparam int V_GEN [NV] = '{0,   0,   1,   0,   0,   1,   0,   0, 0,     0};
    localparam int V_EXP [NV] = '{100, 50,  50,  50,  25,  12,  25,  1, 15625, 7812};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  ivl_long = '0;
    logic [1:0]        row_sel = '0;
    logic              hot = 1'b0;
    logic              gen_short = 1'b0;
    logic [TRFC_W-1:0] trfc = '0;
    logic              ref_gnt = 1'b0;
    logic              sr_req = 1'b0;
    logic              ref_req;
    logic              busy;
    logic [ROW_W-1:0]  row_grp;
    logic              sweep_done;
    logic              sr_ack;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    rfs_sched #(.CNT_W(CNT_W), .TRFC_W(TRFC_W), .ROW_BASE(ROW_BASE), .ROW_W(ROW_W)) uut (
        .clk(clk), .rst_n(rst_n), .ivl_long(ivl_long), .row_sel(row_sel), .hot(hot),
        .gen_short(gen_short), .trfc(trfc), .ref_gnt(ref_gnt), .sr_req(sr_req),
        .ref_req(ref_req), .busy(busy), .row_grp(row_grp), .sweep_done(sweep_done),
        .sr_ack(sr_ack)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        ref_gnt = 1'b0;
        sr_req  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic grant();
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        ivl_long = 16'd10;
        trfc     = 8'd3;
        do_reset();
        check(!ref_req && !busy && !sweep_done && !sr_ack && row_grp == 0, "R1 reset outputs",
              {ref_req, busy, sweep_done, sr_ack}, 0);

        // R2 R3: vector table of interval settings
        for (int v = 0; v < NV; v++) begin
            ivl_long  = CNT_W'(V_IVL[v]);
            row_sel   = 2'(V_SEL[v]);
            hot       = V_HOT[v][0];
            gen_short = V_GEN[v][0];
            do_reset();
            @(negedge clk);
            while (!ref_req && cyc < V_EXP[v] + 3) @(negedge clk);
            check(cyc == V_EXP[v], (V_HOT[v] | V_GEN[v]) != 0 ? "R3 shortened interval" : "R2 interval",
                  cyc, V_EXP[v]);
        end

        // R4 R5 R6: hold, grant, busy window, no drift
        ivl_long = 16'd10; row_sel = 2'd0; hot = 1'b0; gen_short = 1'b0; trfc = 8'd3;
        do_reset();
        wait_cyc(5);
        grant();
        check(row_grp == 0 && !busy, "R4 grant without request ignored", row_grp, 0);
        wait_cyc(9);
        check(!ref_req, "R2 request not early", ref_req, 0);
        wait_cyc(12);
        check(ref_req, "R4 request held", ref_req, 1);
        grant();
        check(!ref_req, "R4 request cleared by grant", ref_req, 0);
        check(busy, "R6 busy opens", busy, 1);
        check(row_grp == 1, "R7 row increments", row_grp, 1);
        wait_cyc(15);
        check(busy, "R6 busy last cycle", busy, 1);
        wait_cyc(16);
        check(!busy, "R6 busy closes", busy, 0);
        wait_cyc(19);
        check(!ref_req, "R5 no early request", ref_req, 0);
        wait_cyc(20);
        check(ref_req, "R5 schedule kept", ref_req, 1);

        // R7: wrap at base count, then at double count
        ivl_long = 16'd4; trfc = 8'd0;
        for (int s = 0; s < 2; s++) begin
            row_sel = 2'(s);
            do_reset();
            for (int i = 0; i < (ROW_BASE << s); i++) begin
                while (!ref_req) @(negedge clk);
                grant();
                check(row_grp == ((i + 1) % (ROW_BASE << s)), "R7 row value", row_grp,
                      (i + 1) % (ROW_BASE << s));
                check(sweep_done == (i == (ROW_BASE << s) - 1), "R7 sweep pulse", sweep_done,
                      i == (ROW_BASE << s) - 1);
            end
            @(negedge clk);
            check(!sweep_done, "R7 sweep one cycle", sweep_done, 0);
        end

        // R8: clamp on switch to shorter interval
        ivl_long = 16'd40; row_sel = 2'd0; hot = 1'b0;
        do_reset();
        wait_cyc(30);
        check(!ref_req, "R8 before switch", ref_req, 0);
        hot = 1'b1;
        @(negedge clk);
        check(ref_req, "R8 clamped request", ref_req, 1);
        hot = 1'b0;

        // R9 R10: self-refresh handshake
        ivl_long = 16'd10; trfc = 8'd2;
        do_reset();
        wait_cyc(10);
        check(ref_req, "R2 request before entry", ref_req, 1);
        sr_req = 1'b1;
        @(negedge clk);
        check(sr_ack, "R9 entry acknowledged", sr_ack, 1);
        check(!ref_req, "R9 pending request dropped", ref_req, 0);
        begin
            int bad = 0;
            while (cyc < 40) begin
                if (cyc == 20) begin
                    grant();
                    check(row_grp == 0 && !busy, "R9 grant ignored in self-refresh", row_grp, 0);
                end else begin
                    @(negedge clk);
                end
                if (ref_req) bad++;
            end
            check(bad == 0, "R9 no request in self-refresh", bad, 0);
        end
        sr_req = 1'b0;
        @(negedge clk);
        check(!sr_ack, "R10 exit acknowledged", sr_ack, 0);
        check(ref_req, "R10 request on exit", ref_req, 1);
        grant();
        check(!ref_req && busy, "R10 exit request granted", ref_req, 0);
        wait_cyc(50);
        check(!ref_req, "R10 timer restarted", ref_req, 0);
        wait_cyc(51);
        check(ref_req, "R10 next request", ref_req, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule